// File: doc/BRIEF.md
# TMDS Four-Lane Pin Serializer

This block turns a stream of colour-symbol triples into a single byte-wide pin word per bit tick, ready for an output port running at ten times the pixel rate. It sits after three TMDS encoders (red, green, blue), each of which produces one 10-bit symbol per pixel. Over the ten bit ticks that follow a load, the block sends one bit of each symbol per tick, least significant bit first. It also synthesises a fourth lane that carries the pixel clock. Every lane is driven as a differential pair: a true pin next to its complement.

Upstream logic delivers triples over a valid/ready handshake. `sym_ready` is high in only two cases: while the block is idle (no symbol loaded since reset), and during the last bit tick of the symbol in flight. A triple is taken on a clock edge where both `sym_valid` and `sym_ready` are high. The first bit of that triple appears on the pins in the next tick. The link never stalls. If upstream has no triple ready at the symbol boundary, the block sends the previous triple again, so the pixel clock lane keeps running without a gap. While `sym_ready` is low, any value on the data inputs is ignored.

At a 25 MHz pixel rate the pin word changes at 250 MHz. The block runs entirely in that bit-clock domain.

Top module: `tmds_pin_packer`

## Requirements
- R1: After reset, and until the first triple is taken, every positive pin is 0 and every negative pin is 1, so `pin_word` equals 8'h55.
- R2: In the k-th tick after a triple is taken (k = 0..9), the pair bits carry bit k of each symbol, so each symbol goes out least significant bit first.
- R3: `pin_word` bits from 7 down to 0 are red true, red complement, green true, green complement, blue true, blue complement, clock true, clock complement.
- R4: Each odd bit of `pin_word` and the even bit just below it are complements of each other in every tick.
- R5: While running, the clock-lane true pin (bit 1) is 1 at bit positions 0 to 4 and 0 at bit positions 5 to 9 of every symbol.
- R6: While running, `sym_ready` is high only in the tick at bit position 9, one tick before the next position 0.
- R7: If `sym_valid` is low at a symbol boundary, the previous triple is sent again in full, and the clock lane continues with no gap.
- R8: A triple presented while `sym_ready` is low is ignored and has no effect on the pins.
- R9: While idle, `sym_ready` is high, and a triple that is taken appears at bit position 0 in the very next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, ten ticks per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Upstream offers a symbol triple |
| sym_ready | output | 1 | Block takes a triple at this edge if valid |
| sym_red | input | 10 | Red lane TMDS symbol |
| sym_green | input | 10 | Green lane TMDS symbol |
| sym_blue | input | 10 | Blue lane TMDS symbol |
| pin_word | output | 8 | Packed differential pin word for the current bit tick |

## Verification
The bench builds the block with its default parameters: 10-bit symbols and three colour lanes. This gives the full byte-wide pin order and a clock lane that is high for five ticks and low for five. The bench deserialises every symbol back from the pin stream. Its stimulus includes symbols with all bits set, all bits clear and alternating bits, as well as the blanking control codes. These expose errors in bit order and lane order. With these parameters, the same run also reaches the underrun repeat, data offered while `sym_ready` is low, and a reset during a symbol followed by a fresh start.

// File: rtl/tmds_pack_pkg.sv
package tmds_pack_pkg;

  typedef enum logic {
    LINK_IDLE = 1'b0,
    LINK_RUN  = 1'b1
  } link_state_e;

  // Drive one differential pair: true pin above complement pin.
  function automatic logic [1:0] pair_drive(input logic b);
    return {b, ~b};
  endfunction

endpackage

// File: rtl/tmds_bit_phase.sv
module tmds_bit_phase
  import tmds_pack_pkg::*;
#(
  parameter int SYM_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  output logic                       running,
  output logic [$clog2(SYM_W)-1:0]   pos,
  output logic                       ready,
  output logic                       lane_clk
);
  localparam int PW = $clog2(SYM_W);
  localparam logic [PW-1:0] LAST_P = PW'(SYM_W - 1);
  localparam logic [PW-1:0] HALF_P = PW'(SYM_W / 2);

  link_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LINK_IDLE;
      pos     <= '0;
    end else if (take) begin
      state_q <= LINK_RUN;
      pos     <= '0;
    end else if (state_q == LINK_RUN) begin
      pos <= (pos == LAST_P) ? '0 : pos + PW'(1);
    end
  end

  assign running  = (state_q == LINK_RUN);
  assign ready    = !running || (pos == LAST_P);
  assign lane_clk = running && (pos < HALF_P);

  // R6
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pos <= LAST_P));

endmodule

// File: rtl/tmds_symbol_slot.sv
module tmds_symbol_slot #(
  parameter int SYM_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [SYM_W-1:0]           sym_in,
  input  logic [$clog2(SYM_W)-1:0]   pos,
  output logic [SYM_W-1:0]           sym_q,
  output logic                       bit_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sym_q <= '0;
    else if (load) sym_q <= sym_in;
  end

  assign bit_out = sym_q[pos];

endmodule

// File: rtl/tmds_pin_pack.sv
module tmds_pin_pack
  import tmds_pack_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                     running,
  input  logic [LANES-1:0]         lane_bits,
  input  logic                     clk_bit,
  output logic [2*(LANES+1)-1:0]   pins
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign pins[2*i+3 -: 2] = pair_drive(running & lane_bits[i]);
  end

  assign pins[1:0] = pair_drive(running & clk_bit);

endmodule

// File: rtl/tmds_pin_packer.sv
module tmds_pin_packer #(
  parameter int SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_red,
  input  logic [SYM_W-1:0] sym_green,
  input  logic [SYM_W-1:0] sym_blue,
  output logic [7:0]       pin_word
);
  localparam int LANES = 3;
  localparam int PW    = $clog2(SYM_W);
  localparam logic [PW-1:0] LAST_P = PW'(SYM_W - 1);
  localparam logic [PW-1:0] HALF_P = PW'(SYM_W / 2);
  localparam logic [2*(LANES+1)-1:0] NEG_MASK = {(LANES+1){2'b01}};

  logic             take;
  logic             running;
  logic             lane_clk;
  logic [PW-1:0]    pos;
  logic [LANES-1:0] lane_bits;
  logic [SYM_W-1:0] sym_in [LANES];
  logic [SYM_W-1:0] sym_q  [LANES];

  assign take = sym_valid & sym_ready;

  // Lane index 2 is red (top pair), 0 is blue.
  assign sym_in[2] = sym_red;
  assign sym_in[1] = sym_green;
  assign sym_in[0] = sym_blue;

  tmds_bit_phase #(.SYM_W(SYM_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .take(take), .running(running),
    .pos(pos), .ready(sym_ready), .lane_clk(lane_clk)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_slot
    tmds_symbol_slot #(.SYM_W(SYM_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(take), .sym_in(sym_in[i]),
      .pos(pos), .sym_q(sym_q[i]), .bit_out(lane_bits[i])
    );
  end

  tmds_pin_pack #(.LANES(LANES)) u_pack (
    .running(running), .lane_bits(lane_bits), .clk_bit(lane_clk),
    .pins(pin_word)
  );

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pin_word == NEG_MASK));

  // R2
  lsb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pin_word[7] == $past(sym_red[0])) && (pin_word[3] == $past(sym_blue[0])));

  // R4
  pair_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_word & NEG_MASK) == ((~pin_word >> 1) & NEG_MASK));

  // R5
  clk_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pin_word[1] == (pos < HALF_P)));

  // R6
  ready_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sym_ready) |-> (pos == LAST_P));

  // R6
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pos != LAST_P) |=> (pos == $past(pos) + PW'(1)));

  // R7
  repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pos == LAST_P && !sym_valid) |=>
      ($stable({sym_q[2], sym_q[1], sym_q[0]}) && running && pos == '0));

  // R8
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> $stable({sym_q[2], sym_q[1], sym_q[0]}));

  // R9
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && sym_valid) |=> (running && pos == '0));

endmodule

// File: tb/sim_tmds_pin_packer.sv
module sim_tmds_pin_packer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic       sym_ready;
  logic [9:0] sym_red = '0, sym_green = '0, sym_blue = '0;
  logic [7:0] pin_word;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tmds_pin_packer u0 (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_red(sym_red), .sym_green(sym_green), .sym_blue(sym_blue),
    .pin_word(pin_word)
  );

  // Stimulus table {red, green, blue}; expected pins are derived per tick.
  localparam logic [29:0] VEC [8] = '{
    {10'b1101010100, 10'b1101010100, 10'b0010101011},
    {10'h3FF, 10'h000, 10'h2AA},
    {10'h155, 10'h3FF, 10'h000},
    {10'h001, 10'h200, 10'h0F0},
    {10'h30F, 10'h0C3, 10'h1E1},
    {10'b0101010100, 10'b1010101011, 10'h123},
    {10'h2B4, 10'h14B, 10'h3C0},
    {10'h00F, 10'h3E0, 10'h1FF}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [29:0] t, input int p);
    logic [9:0] r, g, b;
    logic c;
    {r, g, b} = t;
    c = (p < 5);
    return {r[p], ~r[p], g[p], ~g[p], b[p], ~b[p], c, ~c};
  endfunction

  task automatic offer(input bit v, input logic [29:0] t);
    sym_valid = v;
    {sym_red, sym_green, sym_blue} = t;
  endtask

  // Checks the ten ticks of one symbol; drives the next offer at position 9.
  task automatic run_symbol(input logic [29:0] t, input bit has_next,
                            input logic [29:0] nxt, input bit inject);
    logic [9:0] rr, gg, bb;
    for (int p = 0; p < 10; p++) begin
      @(negedge clk);
      check(pin_word == model(t, p), "R2/R3/R5 pin word", pin_word, model(t, p));
      check(pin_word[1] == (p < 5), "R5 clock lane", pin_word[1], (p < 5));
      for (int k = 0; k < 4; k++)
        check(pin_word[2*k] == ~pin_word[2*k+1], "R4 pair complement",
              pin_word, k);
      check(sym_ready == (p == 9), "R6 ready timing", sym_ready, (p == 9));
      rr[p] = pin_word[7];
      gg[p] = pin_word[5];
      bb[p] = pin_word[3];
      if (inject && p == 3) offer(1'b1, ~t);
      if (p == 9) offer(has_next, nxt);
    end
    check({rr, gg, bb} == t, "R2 recovered symbols", {rr, gg, bb}, t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pin_word == 8'h55, "R1 reset pins", pin_word, 8'h55);
    check(sym_ready == 1'b1, "R9 ready while idle", sym_ready, 1);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(pin_word == 8'h55, "R1 idle pins", pin_word, 8'h55);
    end
    // Table walk: back-to-back triples with valid held high.
    offer(1'b1, VEC[0]);
    for (int i = 0; i < 8; i++)
      run_symbol(VEC[i], (i < 7), VEC[(i + 1) % 8], 1'b0);
    // R7: underrun repeats the last triple.
    run_symbol(VEC[7], 1'b0, '0, 1'b0);
    // R8: a triple offered mid-symbol is ignored; a real one follows.
    run_symbol(VEC[7], 1'b1, VEC[2], 1'b1);
    run_symbol(VEC[2], 1'b0, '0, 1'b0);
    // R1: reset in the middle of a symbol returns to idle.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(pin_word == 8'h55, "R1 pins after mid-symbol reset", pin_word, 8'h55);
    check(sym_ready == 1'b1, "R9 ready after reset", sym_ready, 1);
    // R9: restart; the first bit shows in the next tick.
    rst_n = 1'b1;
    offer(1'b1, VEC[4]);
    run_symbol(VEC[4], 1'b0, '0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule